// File: doc/BRIEF.md
# Variable-length instruction fetch aligner

This block sits between a 32-bit instruction memory port and the decode stage of a small interleaved multithreaded core. Instructions come in two lengths, 16 and 32 bits. A 32-bit instruction may start at either halfword of a fetched word, so it can straddle two words. The aligner keeps each thread's leftover halfword between fetches. It joins the two halves of a straddling instruction and hands decode one complete instruction at a time, together with its length.

The core runs its threads in strict rotation, one thread per clock cycle. The block holds one aligner lane per thread and a slot counter that names the thread owning the current cycle. The word, its valid flag and the redirect inputs always belong to the thread in the current slot. Only that thread's lane may change state in that cycle, so each lane steps at 1/NTHREAD of the clock rate. When a thread misses in the instruction cache, its word-valid input stays low and only that lane waits. A redirect flushes the lane. When the redirect target is the upper halfword of a word, the lower halfword of the next word is dropped.

Top module: `ifetch_align`

## Requirements
- R1: During and right after reset, instr_vld_o is 0, need_word_o is 1 and slot_o is 0.
- R2: slot_o counts 0, 1, ..., NTHREAD-1 and wraps, advancing by one every clock cycle.
- R3: A first halfword with bit 15 set starts a 32-bit instruction; with bit 15 clear it is a 16-bit instruction. instr_len32_o reports this for every emitted instruction.
- R4: A word whose lower halfword has bit 15 set, fetched with no halfword buffered, is emitted whole in that cycle as a 32-bit instruction.
- R5: When a fetched word holds two 16-bit instructions, the lower one (bits 15:0) is emitted in that cycle. The upper one (bits 31:16) is emitted in the thread's next slot, zero-extended to 32 bits.
- R6: When a 32-bit instruction starts in bits 31:16 of a word, it is emitted once the thread's next word arrives. Its bits 15:0 are the held halfword and its bits 31:16 are bits 15:0 of the new word.
- R7: In a slot where the thread needs a word and word_vld_i is 0, nothing is emitted and the lane keeps its buffered halfword.
- R8: A lane changes state only in its own slot. Inputs given in one thread's slot never affect what another thread emits.
- R9: A redirect in a thread's slot emits nothing and discards that thread's buffered halfword in the same cycle. The word input is ignored in that cycle.
- R10: After a redirect with redirect_odd_i set, bits 15:0 of the thread's next valid word are discarded and decoding starts at bits 31:16.
- R11: While a thread holds a buffered 16-bit instruction, need_word_o is 0 in its slot. The word input is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_i | input | 32 | Fetched word for the thread in the current slot |
| word_vld_i | input | 1 | word_i is valid; low on a cache miss |
| redirect_i | input | 1 | Flush and redirect the current slot's thread |
| redirect_odd_i | input | 1 | Redirect target is the upper halfword of its word |
| instr_o | output | 32 | Emitted instruction; a 16-bit instruction is zero-extended |
| instr_len32_o | output | 1 | Emitted instruction is 32 bits long |
| instr_vld_o | output | 1 | An instruction is emitted this cycle |
| need_word_o | output | 1 | Current slot's lane would consume a word this cycle |
| slot_o | output | 1 | Thread owning the current cycle |

## Verification
The bench builds the block with its defaults: NTHREAD = 2, HALF_W = 16 and length bit 15. This gives two lanes that alternate cycle by cycle. It lets the bench put one thread in a miss, with a straddling half pending, while the other thread keeps fetching. It can also leave a spare 16-bit instruction in one lane across the other lane's slots. A halfword-queue model per thread predicts every emission and need_word_o, including the results of even and odd redirects.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_SKIP  = 2'd1,
    ST_SPARE = 2'd2,
    ST_PEND  = 2'd3
  } lane_st_t;
endpackage

// File: rtl/ifa_rst_sync.sv
module ifa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/ifa_slot_ctr.sv
module ifa_slot_ctr #(
  parameter int NTHREAD = 2,
  localparam int SLOT_W = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(NTHREAD - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == SLOT_MAX) slot_d = '0;
    else                    slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  // R2: rotation wraps after the last thread
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_MAX) |=> (slot_q == '0));
  // R2: otherwise it steps by one
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != SLOT_MAX) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/ifa_lane.sv
module ifa_lane
  import ifa_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int LEN_BIT = 15,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              redir,
  input  logic              redir_odd,
  output logic [WORD_W-1:0] instr,
  output logic              len32,
  output logic              emit,
  output logic              need_word
);
  lane_st_t          state_q, state_d;
  logic [HALF_W-1:0] held_q, held_d;
  logic [HALF_W-1:0] lo_h, hi_h;

  assign lo_h = word[HALF_W-1:0];
  assign hi_h = word[WORD_W-1:HALF_W];

  always_comb begin
    state_d   = state_q;
    held_d    = held_q;
    emit      = 1'b0;
    len32     = 1'b0;
    instr     = '0;
    need_word = (state_q != ST_SPARE);
    if (en) begin
      if (redir) begin
        state_d = redir_odd ? ST_SKIP : ST_EMPTY;
        held_d  = '0;
      end else begin
        unique case (state_q)
          ST_EMPTY: if (word_vld) begin
            emit = 1'b1;
            if (lo_h[LEN_BIT]) begin
              len32   = 1'b1;
              instr   = word;
            end else begin
              instr   = {{HALF_W{1'b0}}, lo_h};
              held_d  = hi_h;
              state_d = hi_h[LEN_BIT] ? ST_PEND : ST_SPARE;
            end
          end
          ST_SKIP: if (word_vld) begin
            if (hi_h[LEN_BIT]) begin
              held_d  = hi_h;
              state_d = ST_PEND;
            end else begin
              emit    = 1'b1;
              instr   = {{HALF_W{1'b0}}, hi_h};
              state_d = ST_EMPTY;
            end
          end
          ST_SPARE: begin
            emit    = 1'b1;
            instr   = {{HALF_W{1'b0}}, held_q};
            held_d  = '0;
            state_d = ST_EMPTY;
          end
          ST_PEND: if (word_vld) begin
            emit    = 1'b1;
            len32   = 1'b1;
            instr   = {lo_h, held_q};
            held_d  = hi_h;
            state_d = hi_h[LEN_BIT] ? ST_PEND : ST_SPARE;
          end
          default: state_d = ST_EMPTY;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      held_q  <= '0;
    end else if (en) begin
      state_q <= state_d;
      held_q  <= held_d;
    end
  end

  // R8: nothing moves outside the lane's own slot
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(state_q) && $stable(held_q)));
  // R7: a missing word produces no output
  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !redir && need_word && !word_vld) |-> !emit);
  // R9: a flush leaves no buffered halfword behind
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && redir) |=> (held_q == '0 && state_q != ST_SPARE && state_q != ST_PEND));
  // R11: a held short instruction goes out without a new word
  p_spare_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !redir && state_q == ST_SPARE) |-> (emit && !len32 && !need_word));
endmodule

// File: rtl/ifetch_align.sv
module ifetch_align #(
  parameter int NTHREAD = 2,
  parameter int HALF_W  = 16,
  parameter int LEN_BIT = 15,
  localparam int WORD_W = 2 * HALF_W,
  localparam int SLOT_W = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              redirect_i,
  input  logic              redirect_odd_i,
  output logic [WORD_W-1:0] instr_o,
  output logic              instr_len32_o,
  output logic              instr_vld_o,
  output logic              need_word_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              rst_n_s;
  logic [SLOT_W-1:0] slot;
  logic [NTHREAD-1:0] lane_en;
  logic [WORD_W-1:0] lane_instr [NTHREAD];
  logic [NTHREAD-1:0] lane_len32, lane_emit, lane_need;

  ifa_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  ifa_slot_ctr #(.NTHREAD(NTHREAD)) u_slot (
    .clk(clk), .rst_n(rst_n_s), .slot_o(slot)
  );

  for (genvar g = 0; g < NTHREAD; g++) begin : g_lane
    assign lane_en[g] = (slot == SLOT_W'(g));
    ifa_lane #(.HALF_W(HALF_W), .LEN_BIT(LEN_BIT)) u_lane (
      .clk(clk), .rst_n(rst_n_s), .en(lane_en[g]),
      .word_vld(word_vld_i), .word(word_i),
      .redir(redirect_i), .redir_odd(redirect_odd_i),
      .instr(lane_instr[g]), .len32(lane_len32[g]),
      .emit(lane_emit[g]), .need_word(lane_need[g])
    );
  end

  always_comb begin
    instr_o       = '0;
    instr_len32_o = 1'b0;
    instr_vld_o   = 1'b0;
    need_word_o   = 1'b0;
    for (int i = 0; i < NTHREAD; i++) begin
      if (lane_en[i]) begin
        instr_o       = lane_instr[i];
        instr_len32_o = lane_len32[i];
        instr_vld_o   = lane_emit[i];
        need_word_o   = lane_need[i];
      end
    end
  end

  assign slot_o = slot;

  // R9: the redirect cycle itself is silent at the ports
  p_redir_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    redirect_i |-> !instr_vld_o);
  // R3: a 32-bit result always carries the length mark in its first half
  p_len_mark_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (instr_vld_o && instr_len32_o) |-> instr_o[LEN_BIT]);
endmodule

// File: tb/test_ifetch_align.sv
module test_ifetch_align;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        redirect_i = 1'b0;
  logic        redirect_odd_i = 1'b0;
  logic [31:0] instr_o;
  logic        instr_len32_o, instr_vld_o, need_word_o;
  logic [0:0]  slot_o;

  int checks = 0;
  int errors = 0;
  int exp_slot = -1;

  logic [15:0] mq [2][3];
  int          mn [2];
  bit          mskip [2];
  logic [33:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_align i_ifetch_align (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .redirect_i(redirect_i), .redirect_odd_i(redirect_odd_i),
    .instr_o(instr_o), .instr_len32_o(instr_len32_o), .instr_vld_o(instr_vld_o),
    .need_word_o(need_word_o), .slot_o(slot_o)
  );

  task automatic push_exp(input int t, input bit l, input logic [31:0] e, input string tag);
    exp_q.push_back({t[0], l, e});
    tag_q.push_back(tag);
  endtask

  // Drive one slot for thread t and advance the halfword model
  task automatic apply(input int t, input bit v, input logic [31:0] w,
                       input bit r, input bit o, input string tag);
    bit exp_need;
    word_vld_i = v; word_i = w; redirect_i = r; redirect_odd_i = o;
    exp_need = !(mn[t] > 0 && !mq[t][0][15]);
    if (exp_slot >= 0) begin
      checks++;
      if (t != exp_slot) begin
        errors++;
        $display("FAIL R2 slot order: got %0d expected %0d", t, exp_slot);
      end
    end
    exp_slot = 1 - t;
    if (r) begin
      mn[t] = 0; mskip[t] = o;
    end else if (mn[t] > 0 && !mq[t][0][15]) begin
      push_exp(t, 1'b0, {16'h0, mq[t][0]}, tag);
      mq[t][0] = mq[t][1]; mq[t][1] = mq[t][2]; mn[t]--;
    end else if (v) begin
      if (!mskip[t]) begin mq[t][mn[t]] = w[15:0]; mn[t]++; end
      mq[t][mn[t]] = w[31:16]; mn[t]++;
      mskip[t] = 1'b0;
      if (mn[t] > 0 && !mq[t][0][15]) begin
        push_exp(t, 1'b0, {16'h0, mq[t][0]}, tag);
        mq[t][0] = mq[t][1]; mq[t][1] = mq[t][2]; mn[t]--;
      end else if (mn[t] >= 2) begin
        push_exp(t, 1'b1, {mq[t][1], mq[t][0]}, tag);
        mq[t][0] = mq[t][2]; mn[t] -= 2;
      end
    end
    @(negedge clk);
    checks++;
    if (need_word_o !== exp_need) begin
      errors++;
      $display("FAIL %s/R11 need_word t%0d: got %b expected %b", tag, t, need_word_o, exp_need);
    end
  endtask

  task automatic do_slot(input int t, input bit v, input logic [31:0] w,
                         input bit r, input bit o, input string tag);
    bit done = 1'b0;
    while (!done) begin
      @(posedge clk); #1;
      if (int'(slot_o) == t) begin
        apply(t, v, w, r, o, tag);
        done = 1'b1;
      end else begin
        apply(int'(slot_o), 1'b0, 32'h0, 1'b0, 1'b0, "R8");
      end
    end
  endtask

  // Monitor: compare every emitted instruction with the scoreboard
  always @(negedge clk) begin
    if (rst_n && instr_vld_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected instr: got %h expected none", instr_o);
      end else begin
        logic [33:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        if ({slot_o, instr_len32_o, instr_o} !== e) begin
          errors++;
          $display("FAIL %s/R3 instr: got t%0d len32=%b %h expected t%0d len32=%b %h",
                   tg, slot_o, instr_len32_o, instr_o, e[33], e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++) begin mn[t] = 0; mskip[t] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (instr_vld_o !== 1'b0 || need_word_o !== 1'b1 || slot_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got vld=%b need=%b slot=%b expected 0 1 0",
               instr_vld_o, need_word_o, slot_o);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (instr_vld_o !== 1'b0 || need_word_o !== 1'b1 || slot_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: got vld=%b need=%b slot=%b expected 0 1 0",
               instr_vld_o, need_word_o, slot_o);
    end

    do_slot(0, 1, 32'h9234_8001, 0, 0, "R4");
    do_slot(1, 1, 32'h1111_2222, 0, 0, "R5");
    do_slot(1, 1, 32'hFFFF_FFFF, 0, 0, "R11");
    do_slot(0, 1, 32'h8AAA_0333, 0, 0, "R6");
    do_slot(0, 1, 32'h0444_0555, 0, 0, "R6");
    do_slot(0, 0, 32'h0, 0, 0, "R5");
    do_slot(1, 1, 32'h8BBB_0666, 0, 0, "R7");
    do_slot(1, 0, 32'hDEAD_BEEF, 0, 0, "R7");
    do_slot(0, 1, 32'h0777_8888, 0, 0, "R8");
    do_slot(1, 0, 32'hDEAD_BEEF, 0, 0, "R7");
    do_slot(0, 1, 32'h0A0A_0B0B, 0, 0, "R8");
    do_slot(1, 1, 32'h0999_0CCC, 0, 0, "R7");
    do_slot(1, 0, 32'h0, 0, 0, "R5");
    do_slot(0, 0, 32'h0, 0, 0, "R8");
    do_slot(0, 1, 32'h8DDD_0101, 0, 0, "R9");
    do_slot(0, 1, 32'h0F0F_8F8F, 1, 0, "R9");
    do_slot(0, 1, 32'h0202_0303, 0, 0, "R9");
    do_slot(0, 0, 32'h0, 0, 0, "R9");
    do_slot(1, 0, 32'h0, 1, 1, "R10");
    do_slot(1, 1, 32'h0404_8505, 0, 0, "R10");
    do_slot(1, 0, 32'h0, 1, 1, "R10");
    do_slot(1, 1, 32'h8606_0707, 0, 0, "R10");
    do_slot(1, 1, 32'h0808_0909, 0, 0, "R6");
    do_slot(1, 0, 32'h0, 0, 0, "R5");
    do_slot(0, 1, 32'h1212_1313, 0, 0, "R9");
    do_slot(0, 0, 32'h0, 1, 0, "R9");
    do_slot(0, 1, 32'h1414_1515, 0, 0, "R9");
    do_slot(0, 0, 32'h0, 0, 0, "R9");
    repeat (4) do_slot(0, 0, 32'h0, 0, 0, "R8");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 pending expectations: got %0d left expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule